// File: doc/BRIEF.md
# Read Strobe Gate Training Sequencer

This block is the controller-side sequencer for the read strobe gate calibration step. It runs once write leveling has finished. It sends the mode-register writes that prepare the DRAM through a single command port, one command at a time. It then raises an enable toward the PHY's training logic and keeps issuing training reads, spaced apart, until that logic answers. When the answer comes, or when a read budget runs out, it lowers the enable, restores the normal data path and reports completion.

A single input selects the memory family when a run starts. DDR3/DDR4 parts need the multi-purpose register path switched on before training and switched off after it, and they train with ordinary READ commands. LPDDR3 parts skip that path and train with mode-register reads that alternate between two registers. The PHY's delay search, the DRAM itself and read-valid latency calibration belong to other blocks.

Top module: `gate_train_seq`

## Requirements
- R1: A run starts only on `start` while idle, and `mem_lp` is captured at that moment. The first command is a mode-register write (`cmd_kind` 0) with `cmd_bit` 7 and `cmd_val` 0. It goes to register 1 when `mem_lp`=0 and to register 2 when `mem_lp`=1. After reset the block is idle with `cmd_req`, `gate_en`, `done` and `err` low.
- R2: With `mem_lp`=0, the second command is a mode-register write to register 3 with `cmd_bit` 2 and `cmd_val` 1. With `mem_lp`=1 this write is skipped.
- R3: `gate_en` is high from the first training read request until the loop ends. It is high at every read handshake and low at every mode-register write handshake.
- R4: With `mem_lp`=0, training reads are `cmd_kind` 1 with `cmd_reg` 0. With `mem_lp`=1 they are mode-register reads, `cmd_kind` 2, to register 32, then 40, then 32, and so on. For all reads `cmd_bit` and `cmd_val` are 0.
- R5: Two consecutive training read handshakes are at least `MIN_GAP` cycles apart. When every command is acknowledged in the cycle it is first offered with `L` cycles of wait, the spacing is exactly `MIN_GAP`+`L`.
- R6: A response during the gap after a read ends the loop at once, and no further read is issued. A response while a read is still waiting for its acknowledge lets that read complete, and then the loop ends.
- R7: If `MAX_READS` reads have been issued and the gap after the last one expires with no response, the loop ends as a timeout.
- R8: After the loop ends, `gate_en` falls before any further command. With `mem_lp`=0, the last command is a mode-register write to register 3 with `cmd_bit` 2 and `cmd_val` 0. With `mem_lp`=1 there is no further command.
- R9: A command is held on the port with unchanged fields until `cmd_ack` is sampled high with `cmd_req`. Only then does the sequencer move on.
- R10: `done` is a single-cycle pulse at the end of each run. `err` is high only together with `done`, and only after a timeout.
- R11: `start` pulses while a run is in progress have no effect on the command sequence or on the number of `done` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a training run (idle only) |
| mem_lp | input | 1 | Memory family: 0 DDR3/DDR4, 1 LPDDR3 |
| done | output | 1 | One-cycle end-of-run pulse |
| err | output | 1 | With `done`: run ended by timeout |
| cmd_req | output | 1 | Command offered |
| cmd_ack | input | 1 | Command accepted this cycle |
| cmd_kind | output | 2 | 0 mode-register write, 1 READ, 2 mode-register read |
| cmd_reg | output | 6 | Mode-register index |
| cmd_bit | output | 3 | Bit position written by a mode-register write |
| cmd_val | output | 1 | Value written to that bit |
| gate_en | output | 1 | Gate-training enable toward the PHY |
| gate_resp | input | 1 | Training logic reports the gate is placed |

## Verification
Some properties are checked on every cycle. A command must stay stable until it is acknowledged. No mode-register write may appear while the enable is high, and every read must be under the enable. Read handshakes must keep their minimum spacing. No new read may start after a response has been seen. `done` must be a single pulse, and `err` may only appear with it. The bench scenarios are needed for the rest: the exact command order for each memory family, the alternation of the two read registers, the read count at which each response or timeout ends the loop, and the fact that a mid-run `start` leaves the trace unchanged.

// File: rtl/gts_pkg.sv
package gts_pkg;

    localparam int REG_W = 6;
    localparam int BIT_W = 3;

    typedef enum logic [1:0] {
        CMD_MRW = 2'd0,
        CMD_RD  = 2'd1,
        CMD_MRR = 2'd2
    } cmd_kind_e;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_WL_OFF,
        OP_MPR_ON,
        OP_READ,
        OP_MPR_OFF
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WL_OFF,
        ST_MPR_ON,
        ST_RD_REQ,
        ST_RD_GAP,
        ST_DROP,
        ST_MPR_OFF,
        ST_FIN
    } state_e;

    typedef struct packed {
        logic             req;
        cmd_kind_e        kind;
        logic [REG_W-1:0] regn;
        logic [BIT_W-1:0] bitn;
        logic             val;
    } cmd_t;

    localparam logic [REG_W-1:0] MR_WL_DDR = 6'd1;
    localparam logic [REG_W-1:0] MR_WL_LP  = 6'd2;
    localparam logic [REG_W-1:0] MR_PATH   = 6'd3;
    localparam logic [REG_W-1:0] MR_RD_EVN = 6'd32;
    localparam logic [REG_W-1:0] MR_RD_ODD = 6'd40;
    localparam logic [BIT_W-1:0] BIT_WL    = 3'd7;
    localparam logic [BIT_W-1:0] BIT_PATH  = 3'd2;

    function automatic logic [REG_W-1:0] wl_reg(input logic lp);
        return lp ? MR_WL_LP : MR_WL_DDR;
    endfunction

    function automatic logic [REG_W-1:0] lp_read_reg(input logic odd);
        return odd ? MR_RD_ODD : MR_RD_EVN;
    endfunction

    function automatic op_e state_op(input state_e st);
        case (st)
            ST_WL_OFF:  return OP_WL_OFF;
            ST_MPR_ON:  return OP_MPR_ON;
            ST_RD_REQ:  return OP_READ;
            ST_MPR_OFF: return OP_MPR_OFF;
            default:    return OP_NONE;
        endcase
    endfunction

endpackage

// File: rtl/gts_gap_timer.sv
module gts_gap_timer #(
    parameter int MIN_GAP = 62
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic expired
);
    localparam int CW = (MIN_GAP > 2) ? $clog2(MIN_GAP) : 1;
    localparam logic [CW-1:0] RELOAD = CW'(MIN_GAP - 2);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= RELOAD;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/gts_read_tally.sv
module gts_read_tally #(
    parameter int MAX_READS = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic incr,
    output logic at_limit,
    output logic odd
);
    localparam int CW = $clog2(MAX_READS + 1);
    localparam logic [CW-1:0] LIMIT = CW'(MAX_READS);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clear)
            cnt <= '0;
        else if (incr && cnt != LIMIT)
            cnt <= cnt + 1'b1;
    end

    assign at_limit = (cnt == LIMIT);
    assign odd      = cnt[0];
endmodule

// File: rtl/gts_cmd_encode.sv
module gts_cmd_encode
    import gts_pkg::*;
(
    input  op_e  op,
    input  logic lp,
    input  logic odd,
    output cmd_t cmd
);
    always_comb begin
        cmd = '0;
        case (op)
            OP_WL_OFF: begin
                cmd.req  = 1'b1;
                cmd.kind = CMD_MRW;
                cmd.regn = wl_reg(lp);
                cmd.bitn = BIT_WL;
                cmd.val  = 1'b0;
            end
            OP_MPR_ON: begin
                cmd.req  = 1'b1;
                cmd.kind = CMD_MRW;
                cmd.regn = MR_PATH;
                cmd.bitn = BIT_PATH;
                cmd.val  = 1'b1;
            end
            OP_READ: begin
                cmd.req  = 1'b1;
                cmd.kind = lp ? CMD_MRR : CMD_RD;
                cmd.regn = lp ? lp_read_reg(odd) : '0;
            end
            OP_MPR_OFF: begin
                cmd.req  = 1'b1;
                cmd.kind = CMD_MRW;
                cmd.regn = MR_PATH;
                cmd.bitn = BIT_PATH;
                cmd.val  = 1'b0;
            end
            default: cmd = '0;
        endcase
    end
endmodule

// File: rtl/gate_train_seq.sv
module gate_train_seq
    import gts_pkg::*;
#(
    parameter int MIN_GAP   = 62,
    parameter int MAX_READS = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       mem_lp,
    output logic       done,
    output logic       err,
    output logic       cmd_req,
    input  logic       cmd_ack,
    output logic [1:0] cmd_kind,
    output logic [5:0] cmd_reg,
    output logic [2:0] cmd_bit,
    output logic       cmd_val,
    output logic       gate_en,
    input  logic       gate_resp
);
    state_e state, state_nx;
    logic   lp_q;
    logic   tmo_q, tmo_nx;
    logic   resp_seen;
    logic   hs;
    logic   gap_load, gap_expired;
    logic   tally_clear, tally_incr, at_limit, rd_odd;
    cmd_t   cmd;

    assign hs = cmd.req && cmd_ack;

    gts_gap_timer #(.MIN_GAP(MIN_GAP)) u_gap (
        .clk     (clk),
        .rst     (rst),
        .load    (gap_load),
        .expired (gap_expired)
    );

    gts_read_tally #(.MAX_READS(MAX_READS)) u_tally (
        .clk      (clk),
        .rst      (rst),
        .clear    (tally_clear),
        .incr     (tally_incr),
        .at_limit (at_limit),
        .odd      (rd_odd)
    );

    gts_cmd_encode u_enc (
        .op  (state_op(state)),
        .lp  (lp_q),
        .odd (rd_odd),
        .cmd (cmd)
    );

    always_comb begin
        state_nx    = state;
        tmo_nx      = tmo_q;
        gap_load    = 1'b0;
        tally_clear = 1'b0;
        tally_incr  = 1'b0;
        case (state)
            ST_IDLE: begin
                tally_clear = 1'b1;
                if (start) begin
                    state_nx = ST_WL_OFF;
                    tmo_nx   = 1'b0;
                end
            end
            ST_WL_OFF:
                if (hs) state_nx = lp_q ? ST_RD_REQ : ST_MPR_ON;
            ST_MPR_ON:
                if (hs) state_nx = ST_RD_REQ;
            ST_RD_REQ:
                if (hs) begin
                    tally_incr = 1'b1;
                    if (resp_seen || gate_resp) begin
                        state_nx = ST_DROP;
                    end else begin
                        state_nx = ST_RD_GAP;
                        gap_load = 1'b1;
                    end
                end
            ST_RD_GAP:
                if (gate_resp) begin
                    state_nx = ST_DROP;
                end else if (gap_expired) begin
                    if (at_limit) begin
                        state_nx = ST_DROP;
                        tmo_nx   = 1'b1;
                    end else begin
                        state_nx = ST_RD_REQ;
                    end
                end
            ST_DROP:
                state_nx = lp_q ? ST_FIN : ST_MPR_OFF;
            ST_MPR_OFF:
                if (hs) state_nx = ST_FIN;
            ST_FIN:
                state_nx = ST_IDLE;
            default:
                state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            lp_q      <= 1'b0;
            tmo_q     <= 1'b0;
            resp_seen <= 1'b0;
        end else begin
            state <= state_nx;
            tmo_q <= tmo_nx;
            if (state == ST_IDLE && start)
                lp_q <= mem_lp;
            if (state == ST_IDLE)
                resp_seen <= 1'b0;
            else if (state == ST_RD_REQ && gate_resp)
                resp_seen <= 1'b1;
        end
    end

    assign cmd_req  = cmd.req;
    assign cmd_kind = cmd.kind;
    assign cmd_reg  = cmd.regn;
    assign cmd_bit  = cmd.bitn;
    assign cmd_val  = cmd.val;
    assign gate_en  = (state == ST_RD_REQ) || (state == ST_RD_GAP);
    assign done     = (state == ST_FIN);
    assign err      = (state == ST_FIN) && tmo_q;
endmodule

// File: rtl/gate_train_seq_chk.sv
module gate_train_seq_chk #(
    parameter int MIN_GAP = 62
) (
    input logic       clk,
    input logic       rst,
    input logic       done,
    input logic       err,
    input logic       cmd_req,
    input logic       cmd_ack,
    input logic [1:0] cmd_kind,
    input logic [5:0] cmd_reg,
    input logic [2:0] cmd_bit,
    input logic       cmd_val,
    input logic       gate_en,
    input logic       gate_resp
);
    localparam int GW = $clog2(MIN_GAP + 1);
    localparam logic [GW-1:0] GAP_MIN = GW'(MIN_GAP);

    logic          rd_req, rd_hs, new_rd;
    logic          have_prev, rd_pend_q, resp_q;
    logic [GW-1:0] since;

    assign rd_req = cmd_req && (cmd_kind != 2'd0);
    assign rd_hs  = rd_req && cmd_ack;
    assign new_rd = rd_req && !rd_pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            have_prev <= 1'b0;
            since     <= '0;
            rd_pend_q <= 1'b0;
            resp_q    <= 1'b0;
        end else begin
            rd_pend_q <= rd_req && !cmd_ack;
            if (done) begin
                have_prev <= 1'b0;
                resp_q    <= 1'b0;
            end else begin
                if (rd_hs) have_prev <= 1'b1;
                if (gate_en && gate_resp) resp_q <= 1'b1;
            end
            if (rd_hs)
                since <= GW'(1);
            else if (since < GAP_MIN)
                since <= since + 1'b1;
        end
    end

    // R9
    a_r9_hold_until_ack: assert property (@(posedge clk) disable iff (rst)
        cmd_req && !cmd_ack |=> cmd_req && $stable(cmd_kind) && $stable(cmd_reg)
                                && $stable(cmd_bit) && $stable(cmd_val));

    // R3
    a_r3_no_mrw_enabled: assert property (@(posedge clk) disable iff (rst)
        gate_en |-> !(cmd_req && cmd_kind == 2'd0));

    // R3
    a_r3_read_under_en: assert property (@(posedge clk) disable iff (rst)
        rd_req |-> gate_en);

    // R5
    a_r5_read_spacing: assert property (@(posedge clk) disable iff (rst)
        rd_hs && have_prev |-> since >= GAP_MIN);

    // R6
    a_r6_no_read_after_resp: assert property (@(posedge clk) disable iff (rst)
        new_rd |-> !resp_q);

    // R10
    a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R10
    a_r10_err_with_done: assert property (@(posedge clk) disable iff (rst)
        err |-> done);
endmodule

bind gate_train_seq gate_train_seq_chk #(.MIN_GAP(MIN_GAP)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .done      (done),
    .err       (err),
    .cmd_req   (cmd_req),
    .cmd_ack   (cmd_ack),
    .cmd_kind  (cmd_kind),
    .cmd_reg   (cmd_reg),
    .cmd_bit   (cmd_bit),
    .cmd_val   (cmd_val),
    .gate_en   (gate_en),
    .gate_resp (gate_resp)
);

// File: tb/gate_train_seq_bench.sv
module gate_train_seq_bench;
    localparam int MIN_GAP   = 62;
    localparam int MAX_READS = 5;
    localparam int TR_MAX    = 32;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       mem_lp = 1'b0;
    logic       done, err;
    logic       cmd_req;
    logic       cmd_ack = 1'b0;
    logic [1:0] cmd_kind;
    logic [5:0] cmd_reg;
    logic [2:0] cmd_bit;
    logic       cmd_val;
    logic       gate_en;
    logic       gate_resp = 1'b0;

    int n_chk = 0;
    int n_err = 0;

    logic [11:0] tr_cmd [TR_MAX];
    logic        tr_en  [TR_MAX];
    int          tr_cyc [TR_MAX];
    int          ntr;

    always #5 clk = ~clk;

    gate_train_seq #(.MIN_GAP(MIN_GAP), .MAX_READS(MAX_READS)) u_gate_train_seq (
        .clk(clk), .rst(rst), .start(start), .mem_lp(mem_lp),
        .done(done), .err(err),
        .cmd_req(cmd_req), .cmd_ack(cmd_ack), .cmd_kind(cmd_kind),
        .cmd_reg(cmd_reg), .cmd_bit(cmd_bit), .cmd_val(cmd_val),
        .gate_en(gate_en), .gate_resp(gate_resp)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int setup_len(input bit lp);
        return lp ? 1 : 2;
    endfunction

    // {kind[1:0], reg[5:0], bit[2:0], val}
    function automatic logic [11:0] exp_cmd(input bit lp, input int idx);
        int k;
        if (idx == 0) return {2'd0, (lp ? 6'd2 : 6'd1), 3'd7, 1'b0};
        if (!lp && idx == 1) return {2'd0, 6'd3, 3'd2, 1'b1};
        k = idx - setup_len(lp);
        if (lp) return {2'd2, ((k % 2) != 0 ? 6'd40 : 6'd32), 3'd0, 1'b0};
        return {2'd1, 6'd0, 3'd0, 1'b0};
    endfunction

    function automatic logic [11:0] exp_tail();
        return {2'd0, 6'd3, 3'd2, 1'b0};
    endfunction

    function automatic int exp_reads(input int n, input int d);
        if (n < 1 || n > MAX_READS) return MAX_READS;
        if (d >= MIN_GAP) return (n == MAX_READS) ? MAX_READS : n + 1;
        return n;
    endfunction

    function automatic bit exp_timeout(input int n, input int d);
        if (n < 1 || n > MAX_READS) return 1'b1;
        return (n == MAX_READS) && (d >= MIN_GAP);
    endfunction

    task automatic run_case(input bit lp, input int n, input int d,
                            input int lat, input bit poke);
        int  cyc, wcnt, rcnt, dones, tail, nrd, rds, total, prev_rd;
        bit  armed, errv, hung;
        cyc = 0; wcnt = 0; rcnt = 0; dones = 0; tail = -1; nrd = 0;
        armed = 0; errv = 0; hung = 0; ntr = 0;
        mem_lp = lp;
        @(negedge clk);
        start = 1'b1;
        while (1) begin
            @(negedge clk);
            cyc++;
            start = (poke && (cyc == 40 || cyc == 90));
            if (done) begin
                dones++;
                errv = err;
                if (tail < 0) tail = 6;
            end
            if (gate_resp && !gate_en) gate_resp = 1'b0;
            if (armed) begin
                rcnt++;
                if (rcnt == d) begin
                    armed = 0;
                    if (gate_en) gate_resp = 1'b1;
                end
            end
            if (cmd_req) begin
                if (wcnt == lat) begin
                    cmd_ack = 1'b1;
                    wcnt = 0;
                    if (ntr < TR_MAX) begin
                        tr_cmd[ntr] = {cmd_kind, cmd_reg, cmd_bit, cmd_val};
                        tr_en[ntr]  = gate_en;
                        tr_cyc[ntr] = cyc;
                        ntr++;
                    end
                    if (cmd_kind != 2'd0) begin
                        nrd++;
                        if (nrd == n) begin armed = 1; rcnt = 0; end
                    end
                end else begin
                    cmd_ack = 1'b0;
                    wcnt++;
                end
            end else begin
                cmd_ack = 1'b0;
                wcnt = 0;
            end
            if (tail > 0) begin
                tail--;
                if (tail == 0) break;
            end
            if (cyc > 5000) begin hung = 1; break; end
        end
        cmd_ack = 1'b0; gate_resp = 1'b0; start = 1'b0;

        chk(!hung, "R10", "run finished before watchdog", hung, 0);
        rds   = exp_reads(n, d);
        total = setup_len(lp) + rds + (lp ? 0 : 1);
        chk(ntr == total, "R7", "command count", ntr, total);
        chk(dones == 1, "R11", "done pulses per run", dones, 1);
        chk(errv == exp_timeout(n, d), "R10", "err at done", errv, exp_timeout(n, d));
        chk(exp_cmd(lp, 0) == tr_cmd[0], "R1", "write-leveling off command",
            tr_cmd[0], exp_cmd(lp, 0));
        if (!lp)
            chk(exp_cmd(lp, 1) == tr_cmd[1], "R2", "path-select command",
                tr_cmd[1], exp_cmd(lp, 1));
        prev_rd = -1;
        for (int i = setup_len(lp); i < setup_len(lp) + rds && i < ntr; i++) begin
            chk(tr_cmd[i] == exp_cmd(lp, i), "R4", "read command", tr_cmd[i], exp_cmd(lp, i));
            chk(tr_en[i] == 1'b1, "R3", "enable at read", tr_en[i], 1);
            if (prev_rd >= 0)
                chk(tr_cyc[i] - prev_rd == MIN_GAP + lat, "R5", "read spacing",
                    tr_cyc[i] - prev_rd, MIN_GAP + lat);
            prev_rd = tr_cyc[i];
        end
        for (int i = 0; i < setup_len(lp) && i < ntr; i++)
            chk(tr_en[i] == 1'b0, "R3", "enable low at setup write", tr_en[i], 0);
        if (!lp && ntr == total) begin
            chk(tr_cmd[total-1] == exp_tail(), "R8", "path restore command",
                tr_cmd[total-1], exp_tail());
            chk(tr_en[total-1] == 1'b0, "R8", "enable low at restore", tr_en[total-1], 0);
        end
        chk(!cmd_req && !gate_en, "R11", "idle after run", {cmd_req, gate_en}, 0);
    endtask

    initial begin
        int lp, n, d, lat;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!cmd_req && !gate_en && !done && !err, "R1", "reset state",
            {cmd_req, gate_en, done, err}, 0);
        repeat (5) @(negedge clk);
        chk(!cmd_req, "R11", "no command without start", cmd_req, 0);

        // directed corners
        run_case(0, 1, 1, 0, 0);                      // R6 early response, DDR
        run_case(1, 3, MIN_GAP - 1, 0, 0);            // R6 last gap cycle, LPDDR3
        run_case(0, MAX_READS, MIN_GAP - 1, 1, 0);    // R7 answered at the limit
        run_case(1, MAX_READS, MIN_GAP, 0, 0);        // R7 timeout at the limit
        run_case(0, 0, 1, 2, 0);                      // R7 never answered, DDR
        run_case(1, 0, 1, 0, 0);                      // R7 never answered, LPDDR3
        run_case(0, 2, MIN_GAP + 3, 3, 0);            // R6 response on pending read
        run_case(1, 2, MIN_GAP, 1, 1);                // R11 start while busy
        run_case(0, 3, 10, 0, 1);                     // R11 start while busy, DDR

        for (int it = 0; it < 16; it++) begin
            lp  = int'($urandom_range(1, 0));
            lat = int'($urandom_range(3, 0));
            n   = int'($urandom_range(MAX_READS + 1, 0));
            d   = int'($urandom_range(MIN_GAP + lat, 1));
            run_case(lp[0], n, d, lat, it[0]);
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(200000 * 10 - 100);
        n_chk++;
        n_err++;
        $display("FAIL R10 watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule